// File: doc/BRIEF.md
# Per-Core Interval Tick Timer

This block is a local timer for one processor core. It builds on two counters in series. A prescaler divides the input clock by a programmable amount and produces a one-cycle tick. A down-counter counts those ticks and signals an expiry when its count runs out. An expiry sets a sticky status flag. The interrupt line carries that flag gated by an enable bit.

Software drives the block through a 32-bit register port inside a 256-byte window. The interval buffer only takes a new value when the top bit of the written word is set, so a stray write cannot change the period. Each write to the prescaler buffer, the interval buffer or the control register sets its own acknowledge flag, and software clears that flag by writing one to it. In interval mode the down-counter reloads from its buffer on every expiry and keeps producing interrupts. In one-shot mode the hardware stops the down-counter after the first expiry.

Top module: `tick_interval_timer`

## Requirements
- R1: After reset every readable register reads zero and `irq` is low.
- R2: While control bit 0 (prescaler run) is set, the prescaler emits one tick every P+1 clock cycles. P is the prescaler buffer at offset 0x00.
- R3: Control bit 1 enables the down-counter. After a control write that starts the counters, the first expiry is reflected on the outputs exactly (C+1)·(P+1) clock edges after that write's edge. C is the interval buffer.
- R4: A write to the interval buffer (offset 0x08) with bit 31 set loads bits 30:0 into the buffer. With bit 31 clear the buffer keeps its value. Bit 31 always reads back as 0.
- R5: With control bit 2 set (repeat mode), the down-counter reloads from its buffer on each expiry, so expiries recur every (C+1)·(P+1) cycles.
- R6: The status register (offset 0x30) bit 0 is set by an expiry. It stays set until software writes 1 to it.
- R7: `irq` equals status bit 0 AND enable bit 0 (offset 0x34). With the enable bit clear, an expiry still sets status but `irq` stays low.
- R8: With control bit 2 clear (one-shot mode), an expiry clears control bit 1 in hardware, and no further expiry occurs.
- R9: Clearing a run bit freezes that counter. Any 0-to-1 change of control bit 0 or bit 1 reloads the prescaler to zero and the down-counter from its buffer.
- R10: Acknowledge register (offset 0x40) bit 0 is set by a write to 0x00, bit 1 by a write to 0x08, and bit 3 by a write to the control register at 0x20. Each bit is cleared by writing 1 to it. All other bits read 0.
- R11: Reads from offsets with no register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte offset within the register window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The timing tests sweep every pairing of prescaler value 0–3 with interval value 0–3. The exact cycle of the first expiry separates an off-by-one in the prescaler from one in the down-counter, because each error scales the product differently. Where the period is at least two cycles, the cycle of the second expiry confirms the reload in repeat mode. A separate pass stops the prescaler partway through a count and then restarts it; a full-length first period after the restart shows that the counters reloaded instead of resuming. Further tests cover one-shot operation with the interrupt masked and the rules for acknowledge bits and buffer writes.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
    localparam logic [7:0] OFF_PRESCALE = 8'h00;
    localparam logic [7:0] OFF_INTERVAL = 8'h08;
    localparam logic [7:0] OFF_CONTROL  = 8'h20;
    localparam logic [7:0] OFF_STATUS   = 8'h30;
    localparam logic [7:0] OFF_ENABLE   = 8'h34;
    localparam logic [7:0] OFF_ACK      = 8'h40;

    localparam int CTL_RUN_PRE  = 0;
    localparam int CTL_RUN_CNT  = 1;
    localparam int CTL_REPEAT   = 2;

    localparam int ACK_PRE_BIT  = 0;
    localparam int ACK_INT_BIT  = 1;
    localparam int ACK_CTL_BIT  = 3;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reload,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (reload) begin
            cnt_d = '0;
        end else if (run) begin
            if (cnt_q >= limit) begin
                cnt_d = '0;
                tick  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_PRESCALE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/tick_interval_counter.sv
module tick_interval_counter #(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] period,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (reload) begin
            cnt_d = period;
        end else if (enable && tick) begin
            if (cnt_q == '0) begin
                cnt_d  = period;
                expire = 1'b1;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_INTERVAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !reload) |=> $stable(cnt_q)); // R9
    AST_RELOAD_TAKES_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == $past(period))); // R9
endmodule

// File: rtl/tick_interval_timer.sv
module tick_interval_timer
    import tick_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int ICNT_W = DATA_W - 1;

    typedef struct packed {
        logic [TICK_W-1:0] pre;
        logic [ICNT_W-1:0] ivl;
        logic [2:0]        ctl;
        logic              stat;
        logic              enb;
        logic [2:0]        ack;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_pre, wr_ivl, wr_ctl, wr_stat, wr_enb, wr_ack;
    logic restart, tick, expire;

    assign wr_pre  = bus_we && (bus_addr == ADDR_W'(OFF_PRESCALE));
    assign wr_ivl  = bus_we && (bus_addr == ADDR_W'(OFF_INTERVAL));
    assign wr_ctl  = bus_we && (bus_addr == ADDR_W'(OFF_CONTROL));
    assign wr_stat = bus_we && (bus_addr == ADDR_W'(OFF_STATUS));
    assign wr_enb  = bus_we && (bus_addr == ADDR_W'(OFF_ENABLE));
    assign wr_ack  = bus_we && (bus_addr == ADDR_W'(OFF_ACK));

    assign restart = wr_ctl && ((bus_wdata[1:0] & ~r_q.ctl[1:0]) != 2'b00);

    tick_prescaler #(.CNT_W(TICK_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (r_q.ctl[CTL_RUN_PRE]),
        .reload (restart),
        .limit  (r_q.pre),
        .tick   (tick)
    );

    tick_interval_counter #(.CNT_W(ICNT_W)) u_ivl (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (r_q.ctl[CTL_RUN_CNT]),
        .tick   (tick),
        .reload (restart),
        .period (r_q.ivl),
        .expire (expire)
    );

    always_comb begin
        r_d = r_q;
        if (wr_pre) begin
            r_d.pre    = bus_wdata[TICK_W-1:0];
            r_d.ack[0] = 1'b1;
        end
        if (wr_ivl) begin
            if (bus_wdata[DATA_W-1]) r_d.ivl = bus_wdata[ICNT_W-1:0];
            r_d.ack[1] = 1'b1;
        end
        if (expire && !r_q.ctl[CTL_REPEAT]) r_d.ctl[CTL_RUN_CNT] = 1'b0;
        if (wr_ctl) begin
            r_d.ctl    = bus_wdata[2:0];
            r_d.ack[2] = 1'b1;
        end
        if (wr_enb) r_d.enb = bus_wdata[0];
        if (wr_stat && bus_wdata[0]) r_d.stat = 1'b0;
        if (expire) r_d.stat = 1'b1;
        if (wr_ack) begin
            if (bus_wdata[ACK_PRE_BIT]) r_d.ack[0] = 1'b0;
            if (bus_wdata[ACK_INT_BIT]) r_d.ack[1] = 1'b0;
            if (bus_wdata[ACK_CTL_BIT]) r_d.ack[2] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_PRESCALE))      bus_rdata[TICK_W-1:0] = r_q.pre;
        else if (bus_addr == ADDR_W'(OFF_INTERVAL)) bus_rdata[ICNT_W-1:0] = r_q.ivl;
        else if (bus_addr == ADDR_W'(OFF_CONTROL))  bus_rdata[2:0] = r_q.ctl;
        else if (bus_addr == ADDR_W'(OFF_STATUS))   bus_rdata[0] = r_q.stat;
        else if (bus_addr == ADDR_W'(OFF_ENABLE))   bus_rdata[0] = r_q.enb;
        else if (bus_addr == ADDR_W'(OFF_ACK)) begin
            bus_rdata[ACK_PRE_BIT] = r_q.ack[0];
            bus_rdata[ACK_INT_BIT] = r_q.ack[1];
            bus_rdata[ACK_CTL_BIT] = r_q.ack[2];
        end
    end

    assign irq = r_q.stat & r_q.enb;

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.stat && !(wr_stat && bus_wdata[0])) |=> r_q.stat); // R6
    AST_EXPIRY_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> r_q.stat); // R6
    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !r_q.ctl[CTL_REPEAT] && !wr_ctl) |=> !r_q.ctl[CTL_RUN_CNT]); // R8
    AST_PRESCALE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pre |=> r_q.ack[0]); // R10
endmodule

// File: tb/tick_interval_timer_test.sv
`timescale 1ns/1ps
module tick_interval_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tick_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic start(input logic [2:0] ctl);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h20; bus_wdata = {29'd0, ctl};
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int t1, t2, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(irq == 1'b0, "R1 irq", irq, 0);
        rd_check(8'h00, 0, "R1 prescale");
        rd_check(8'h08, 0, "R1 interval");
        rd_check(8'h20, 0, "R1 control");
        rd_check(8'h30, 0, "R1 status");
        rd_check(8'h34, 0, "R1 enable");
        rd_check(8'h40, 0, "R1 ack");
        rd_check(8'h10, 0, "R11 unmapped");

        // R10: acknowledge bits
        wr(8'h00, 32'h1);
        rd_check(8'h40, 32'h1, "R10 ack after prescale write");
        wr(8'h08, 32'h8000_0002);
        rd_check(8'h40, 32'h3, "R10 ack after interval write");
        wr(8'h20, 32'h0);
        rd_check(8'h40, 32'hB, "R10 ack after control write");
        wr(8'h40, 32'h2);
        rd_check(8'h40, 32'h9, "R10 w1c of bit 1");
        wr(8'h40, 32'hF);
        rd_check(8'h40, 32'h0, "R10 w1c all");

        // R4: interval buffer update flag
        wr(8'h08, 32'h0000_0005);
        rd_check(8'h08, 32'h2, "R4 write without flag ignored");
        wr(8'h08, 32'hFFFF_FFFF);
        rd_check(8'h08, 32'h7FFF_FFFF, "R4 31-bit load");
        wr(8'h00, 32'h0000_ABCD);
        rd_check(8'h00, 32'h0000_ABCD, "R2 prescale readback");

        // R2 R3 R5: sweep of prescale and interval values
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 4; c++) begin
                wr(8'h20, 0); wr(8'h30, 1);
                wr(8'h00, p); wr(8'h08, 32'h8000_0000 | c); wr(8'h34, 1);
                n = (c + 1) * (p + 1);
                start(3'b111);
                t1 = 0;
                for (int k = 1; k <= n + 5 && t1 == 0; k++) begin
                    @(negedge clk);
                    if (irq) t1 = k;
                end
                check(t1 == n, "R3 first expiry cycle", t1, n);
                if (n >= 2) begin
                    bus_we = 1'b1; bus_addr = 8'h30; bus_wdata = 1;
                    t2 = 0;
                    for (int k = t1 + 1; k <= 2 * n + 5 && t2 == 0; k++) begin
                        @(negedge clk);
                        bus_we = 1'b0;
                        if (irq) t2 = k;
                    end
                    check(t2 == 2 * n, "R5 repeat expiry cycle", t2, 2 * n);
                end
            end
        end
        wr(8'h20, 0); wr(8'h30, 1);

        // R7 R8: one-shot with interrupt masked (P=1, C=2, period 6)
        wr(8'h00, 1); wr(8'h08, 32'h8000_0002); wr(8'h34, 0);
        start(3'b011);
        repeat (18) @(negedge clk);
        check(irq == 1'b0, "R7 masked irq low", irq, 0);
        rd_check(8'h30, 1, "R6 status set while masked");
        rd_check(8'h20, 1, "R8 hardware cleared counter run bit");
        wr(8'h30, 1);
        repeat (18) @(negedge clk);
        rd_check(8'h30, 0, "R8 no second one-shot expiry");
        wr(8'h34, 1);
        check(irq == 1'b0, "R7 irq low with status clear", irq, 0);
        wr(8'h30, 1);
        wr(8'h34, 1);
        rd_check(8'h30, 0, "R6 status after w1c");

        // R9: freeze then restart reloads
        wr(8'h20, 0);
        start(3'b111);
        repeat (3) @(negedge clk);
        wr(8'h20, 32'h6);
        repeat (40) @(negedge clk);
        check(irq == 1'b0, "R9 frozen prescaler no expiry", irq, 0);
        start(3'b111);
        t1 = 0;
        for (int k = 1; k <= 12 && t1 == 0; k++) begin
            @(negedge clk);
            if (irq) t1 = k;
        end
        check(t1 == 6, "R9 restart reloads full period", t1, 6);
        wr(8'h20, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule